// File: doc/BRIEF.md
# Per-Thread Squash Request Arbiter

This block decides, for every hardware thread of an out-of-order retirement stage, whether a pipeline flush happens in a given cycle and where it starts. It accepts flush requests from the execute stage, which carry a sequence number, an inclusive flag, branch outcome bits and a redirect PC. It also accepts whole-thread flush pulses from the trap path and from an external context-update path. A flush from execute is accepted only when it targets an instruction no younger than the youngest valid one the thread holds, so a flush from a younger instruction cannot override a flush from an older one.

Each accepted flush produces a one-cycle command toward the reorder buffer and a set of broadcast fields for the front-end stages. The thread then stays in a flushing state, and retires nothing, until the reorder buffer reports that its own walk has finished. Instruction insertion events keep the youngest-valid sequence number up to date, and the block ignores them while the thread is flushing.

Top module: `squash_arbiter`

## Requirements
- R1: An execute flush for a thread is accepted only if that thread is not in the trap-waiting state (thr_state code 2) and its sequence number is less than or equal to the thread's youngest valid sequence number; otherwise no command is issued.
- R2: When the inclusive flag of an accepted execute flush is set, the flush point is the given sequence number minus one; otherwise it is the given number.
- R3: An accepted flush raises bc_squash for exactly the cycle after the request, with bc_done_seq equal to the flush point, and, for an execute flush, bc_misp, bc_taken and bc_npc copied from the request. In the same cycle the youngest value equals the flush point and thr_state is 1 (flushing).
- R4: A trap flush and an external flush on the same thread in the same cycle are resolved in favour of the trap flush, and sq_conflict for that thread is high in the following cycle.
- R5: A trap or external flush is a whole-thread flush. Its point is the head sequence number minus one, or 0 when the reorder buffer is empty. It sets youngest to 0, drives bc_misp and bc_taken low, and drives bc_npc from cur_pc.
- R6: A thread in the flushing state stays there, with commit_ok low, until rob_done is seen. It then returns to the running state (code 0), and commit_ok goes high.
- R7: An insertion that is not marked dead, on a thread that is not flushing, sets youngest to the inserted sequence number. Insertions that are marked dead, or that arrive while the thread is flushing or in the cycle a flush is accepted, leave youngest unchanged.
- R8: A trap flush clears both trap_pend and sys_mode. An external flush clears sys_mode only. trap_arm sets trap_pend and puts the thread in the trap-waiting state. sys_enter sets sys_mode.
- R9: After reset every thread is running with youngest 0, and every flag and broadcast output is 0.
- R10: A trap or external flush on a thread overrides an execute flush on the same thread in the same cycle. The command carries the whole-thread flush point and fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_sq_vld | input | NTHR | Execute flush request per thread |
| ex_sq_seq | input | NTHR*SEQW | Flushing instruction sequence number |
| ex_sq_incl | input | NTHR | Include the flushing instruction |
| ex_sq_misp | input | NTHR | Request is a branch mispredict |
| ex_sq_taken | input | NTHR | Branch outcome taken |
| ex_sq_npc | input | NTHR*PCW | Redirect PC of the request |
| trap_sq | input | NTHR | Trap flush pulse |
| ext_sq | input | NTHR | External context flush pulse |
| trap_arm | input | NTHR | A trap has been raised; wait for its flush |
| sys_enter | input | NTHR | Thread enters privileged state-update mode |
| ins_vld | input | NTHR | Instruction inserted this cycle |
| ins_seq | input | NTHR*SEQW | Inserted sequence number |
| ins_dead | input | NTHR | Inserted instruction already squashed |
| rob_empty | input | NTHR | Thread has no reorder buffer entries |
| rob_head_seq | input | NTHR*SEQW | Sequence number at the thread's head |
| rob_done | input | NTHR | Reorder buffer finished its flush walk |
| cur_pc | input | NTHR*PCW | Restart PC for whole-thread flushes |
| bc_squash | output | NTHR | One-cycle flush command |
| bc_done_seq | output | NTHR*SEQW | Flush point |
| bc_misp | output | NTHR | Broadcast mispredict bit |
| bc_taken | output | NTHR | Broadcast taken bit |
| bc_npc | output | NTHR*PCW | Broadcast redirect PC |
| thr_state | output | NTHR*2 | 0 running, 1 flushing, 2 trap-waiting |
| commit_ok | output | NTHR | Thread may retire this cycle |
| youngest | output | NTHR*SEQW | Youngest valid sequence number |
| trap_pend | output | NTHR | Trap flush outstanding |
| sys_mode | output | NTHR | State-update mode flag |
| sq_conflict | output | NTHR | Trap and external flush collided |

## Verification
Some properties are checked on every cycle. A filtered request never produces a command. A command always coincides with the flushing state. A thread stays flushing until the reorder buffer says it is done. A whole-thread flush zeroes youngest and clears the flags. A collision always raises the conflict output. The bench scenarios are needed for the arithmetic and the data paths: the inclusive minus-one, the empty-buffer zero point, the copying of branch bits and PCs, the dropping of dead or late insertions, and the isolation between threads.

// File: rtl/sq_pkg.sv
package sq_pkg;
   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_SQ   = 2'd1,
      ST_TRAP = 2'd2
   } sq_state_t;
endpackage

// File: rtl/sq_thread_ctl.sv
module sq_thread_ctl
   import sq_pkg::*;
#(
   parameter int SEQW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ex_vld,
   input  logic [SEQW-1:0] ex_seq,
   input  logic            ex_incl,
   input  logic            trap_sq,
   input  logic            ext_sq,
   input  logic            trap_arm,
   input  logic            sys_enter,
   input  logic            ins_vld,
   input  logic [SEQW-1:0] ins_seq,
   input  logic            ins_dead,
   input  logic            rob_empty,
   input  logic [SEQW-1:0] rob_head,
   input  logic            rob_done,
   output logic            take,
   output logic            take_all,
   output logic [SEQW-1:0] take_pt,
   output sq_state_t       st_q,
   output logic [SEQW-1:0] yng_q,
   output logic            tpend_q,
   output logic            sys_q,
   output logic            conf_q
);
   sq_state_t       base_st, st_d;
   logic            ex_ok, ex_take;
   logic [SEQW-1:0] all_pt, ex_pt, yng_d;

   always_comb begin
      base_st  = (st_q == ST_SQ && rob_done) ? ST_RUN : st_q;
      take_all = trap_sq | ext_sq;
      ex_ok    = ex_vld && (st_q != ST_TRAP) && (ex_seq <= yng_q);
      ex_take  = ex_ok && !take_all;
      take     = take_all | ex_take;
      all_pt   = rob_empty ? '0 : rob_head - SEQW'(1);
      ex_pt    = ex_incl ? ex_seq - SEQW'(1) : ex_seq;
      take_pt  = take_all ? all_pt : ex_pt;

      if (take)          st_d = ST_SQ;
      else if (trap_arm) st_d = ST_TRAP;
      else               st_d = base_st;

      if (take_all)     yng_d = '0;
      else if (ex_take) yng_d = ex_pt;
      else if (ins_vld && !ins_dead && base_st != ST_SQ) yng_d = ins_seq;
      else              yng_d = yng_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_RUN;
         yng_q   <= '0;
         tpend_q <= 1'b0;
         sys_q   <= 1'b0;
         conf_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         yng_q  <= yng_d;
         conf_q <= trap_sq & ext_sq;
         if (trap_sq)       tpend_q <= 1'b0;
         else if (trap_arm) tpend_q <= 1'b1;
         if (take_all)       sys_q <= 1'b0;
         else if (sys_enter) sys_q <= 1'b1;
      end
   end

   a_r6_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SQ && !rob_done && !take && !trap_arm) |=> st_q == ST_SQ);
   a_r8_trap_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
      trap_sq |=> (!tpend_q && !sys_q));
   a_r5_whole_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_sq || ext_sq) |=> yng_q == '0);
endmodule

// File: rtl/sq_bcast_reg.sv
module sq_bcast_reg #(
   parameter int SEQW      = 16,
   parameter int PCW       = 32,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take,
   input  logic            take_all,
   input  logic [SEQW-1:0] take_pt,
   input  logic            ex_misp,
   input  logic            ex_taken,
   input  logic [PCW-1:0]  ex_npc,
   input  logic [PCW-1:0]  cur_pc,
   output logic            sq_q,
   output logic [SEQW-1:0] pt_q,
   output logic            misp_q,
   output logic            taken_q,
   output logic [PCW-1:0]  npc_q
);
   logic           misp_d, taken_d;
   logic [PCW-1:0] npc_d;

   always_comb begin
      misp_d  = take_all ? 1'b0 : ex_misp;
      taken_d = take_all ? 1'b0 : ex_taken;
      npc_d   = take_all ? cur_pc : ex_npc;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sq_q <= 1'b0;
      else        sq_q <= take;
   end

   generate
      if (ZERO_IDLE) begin : g_zero
         always_ff @(posedge clk) begin
            if (!rst_n || !take) begin
               pt_q    <= '0;
               misp_q  <= 1'b0;
               taken_q <= 1'b0;
               npc_q   <= '0;
            end else begin
               pt_q    <= take_pt;
               misp_q  <= misp_d;
               taken_q <= taken_d;
               npc_q   <= npc_d;
            end
         end
      end else begin : g_hold
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pt_q    <= '0;
               misp_q  <= 1'b0;
               taken_q <= 1'b0;
               npc_q   <= '0;
            end else if (take) begin
               pt_q    <= take_pt;
               misp_q  <= misp_d;
               taken_q <= taken_d;
               npc_q   <= npc_d;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/squash_arbiter.sv
module squash_arbiter
   import sq_pkg::*;
#(
   parameter int NTHR      = 2,
   parameter int SEQW      = 16,
   parameter int PCW       = 32,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NTHR-1:0]      ex_sq_vld,
   input  logic [NTHR*SEQW-1:0] ex_sq_seq,
   input  logic [NTHR-1:0]      ex_sq_incl,
   input  logic [NTHR-1:0]      ex_sq_misp,
   input  logic [NTHR-1:0]      ex_sq_taken,
   input  logic [NTHR*PCW-1:0]  ex_sq_npc,
   input  logic [NTHR-1:0]      trap_sq,
   input  logic [NTHR-1:0]      ext_sq,
   input  logic [NTHR-1:0]      trap_arm,
   input  logic [NTHR-1:0]      sys_enter,
   input  logic [NTHR-1:0]      ins_vld,
   input  logic [NTHR*SEQW-1:0] ins_seq,
   input  logic [NTHR-1:0]      ins_dead,
   input  logic [NTHR-1:0]      rob_empty,
   input  logic [NTHR*SEQW-1:0] rob_head_seq,
   input  logic [NTHR-1:0]      rob_done,
   input  logic [NTHR*PCW-1:0]  cur_pc,
   output logic [NTHR-1:0]      bc_squash,
   output logic [NTHR*SEQW-1:0] bc_done_seq,
   output logic [NTHR-1:0]      bc_misp,
   output logic [NTHR-1:0]      bc_taken,
   output logic [NTHR*PCW-1:0]  bc_npc,
   output logic [NTHR*2-1:0]    thr_state,
   output logic [NTHR-1:0]      commit_ok,
   output logic [NTHR*SEQW-1:0] youngest,
   output logic [NTHR-1:0]      trap_pend,
   output logic [NTHR-1:0]      sys_mode,
   output logic [NTHR-1:0]      sq_conflict
);
   localparam int STW = $bits(sq_state_t);

   initial begin
      if (NTHR < 1) $error("squash_arbiter: NTHR must be at least 1");
      if (SEQW < 2) $error("squash_arbiter: SEQW must be at least 2");
      if (PCW < 1)  $error("squash_arbiter: PCW must be at least 1");
   end

   for (genvar t = 0; t < NTHR; t++) begin : g_thr
      logic            take, take_all;
      logic [SEQW-1:0] take_pt, yng;
      sq_state_t       st;

      sq_thread_ctl #(.SEQW(SEQW)) u_ctl (
         .clk       (clk),
         .rst_n     (rst_n),
         .ex_vld    (ex_sq_vld[t]),
         .ex_seq    (ex_sq_seq[t*SEQW +: SEQW]),
         .ex_incl   (ex_sq_incl[t]),
         .trap_sq   (trap_sq[t]),
         .ext_sq    (ext_sq[t]),
         .trap_arm  (trap_arm[t]),
         .sys_enter (sys_enter[t]),
         .ins_vld   (ins_vld[t]),
         .ins_seq   (ins_seq[t*SEQW +: SEQW]),
         .ins_dead  (ins_dead[t]),
         .rob_empty (rob_empty[t]),
         .rob_head  (rob_head_seq[t*SEQW +: SEQW]),
         .rob_done  (rob_done[t]),
         .take      (take),
         .take_all  (take_all),
         .take_pt   (take_pt),
         .st_q      (st),
         .yng_q     (yng),
         .tpend_q   (trap_pend[t]),
         .sys_q     (sys_mode[t]),
         .conf_q    (sq_conflict[t])
      );

      sq_bcast_reg #(.SEQW(SEQW), .PCW(PCW), .ZERO_IDLE(ZERO_IDLE)) u_bc (
         .clk      (clk),
         .rst_n    (rst_n),
         .take     (take),
         .take_all (take_all),
         .take_pt  (take_pt),
         .ex_misp  (ex_sq_misp[t]),
         .ex_taken (ex_sq_taken[t]),
         .ex_npc   (ex_sq_npc[t*PCW +: PCW]),
         .cur_pc   (cur_pc[t*PCW +: PCW]),
         .sq_q     (bc_squash[t]),
         .pt_q     (bc_done_seq[t*SEQW +: SEQW]),
         .misp_q   (bc_misp[t]),
         .taken_q  (bc_taken[t]),
         .npc_q    (bc_npc[t*PCW +: PCW])
      );

      assign thr_state[t*STW +: STW] = st;
      assign youngest[t*SEQW +: SEQW] = yng;
      assign commit_ok[t] = (st == ST_RUN);

      a_r1_filter_younger: assert property (@(posedge clk) disable iff (!rst_n)
         (!trap_sq[t] && !ext_sq[t] &&
          (st == ST_TRAP || ex_sq_seq[t*SEQW +: SEQW] > yng))
         |=> !bc_squash[t]);
      a_r3_cmd_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
         bc_squash[t] |-> st == ST_SQ);
      a_r4_conflict_flag: assert property (@(posedge clk) disable iff (!rst_n)
         (trap_sq[t] && ext_sq[t]) |=> sq_conflict[t]);
   end
endmodule

// File: tb/tb_squash_arbiter.sv
`timescale 1ns/1ps
module tb_squash_arbiter;
   localparam int NTHR = 2;
   localparam int SEQW = 16;
   localparam int PCW  = 32;

   logic clk = 1'b0;
   logic rst_n;
   always #2.5 clk = ~clk;

   logic [NTHR-1:0]      ex_sq_vld, ex_sq_incl, ex_sq_misp, ex_sq_taken;
   logic [NTHR*SEQW-1:0] ex_sq_seq, ins_seq, rob_head_seq;
   logic [NTHR*PCW-1:0]  ex_sq_npc, cur_pc;
   logic [NTHR-1:0]      trap_sq, ext_sq, trap_arm, sys_enter;
   logic [NTHR-1:0]      ins_vld, ins_dead, rob_empty, rob_done;
   logic [NTHR-1:0]      bc_squash, bc_misp, bc_taken, commit_ok;
   logic [NTHR-1:0]      trap_pend, sys_mode, sq_conflict;
   logic [NTHR*SEQW-1:0] bc_done_seq, youngest;
   logic [NTHR*PCW-1:0]  bc_npc;
   logic [NTHR*2-1:0]    thr_state;

   squash_arbiter #(.NTHR(NTHR), .SEQW(SEQW), .PCW(PCW)) dut (.*);

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle();
      ex_sq_vld = '0; ex_sq_incl = '0; ex_sq_misp = '0; ex_sq_taken = '0;
      trap_sq = '0; ext_sq = '0; trap_arm = '0; sys_enter = '0;
      ins_vld = '0; ins_dead = '0; rob_done = '0;
   endtask

   task automatic step();
      @(negedge clk);
      idle();
   endtask

   function automatic logic [SEQW-1:0] yng(input int t);
      return youngest[t*SEQW +: SEQW];
   endfunction
   function automatic logic [SEQW-1:0] dseq(input int t);
      return bc_done_seq[t*SEQW +: SEQW];
   endfunction
   function automatic logic [1:0] st(input int t);
      return thr_state[t*2 +: 2];
   endfunction

   task automatic insert(input int t, input logic [SEQW-1:0] s, input logic dead);
      ins_vld[t] = 1'b1; ins_dead[t] = dead; ins_seq[t*SEQW +: SEQW] = s;
      step();
   endtask

   task automatic exsq(input int t, input logic [SEQW-1:0] s, input logic inc,
                       input logic mp, input logic tk, input logic [PCW-1:0] pc);
      ex_sq_vld[t] = 1'b1; ex_sq_incl[t] = inc; ex_sq_misp[t] = mp;
      ex_sq_taken[t] = tk; ex_sq_seq[t*SEQW +: SEQW] = s;
      ex_sq_npc[t*PCW +: PCW] = pc;
   endtask

   task automatic finish_walk(input int t);
      rob_done[t] = 1'b1;
      step();
   endtask

   typedef struct packed {
      logic [15:0] y;
      logic [15:0] s;
      logic        inc;
      logic        acc;
      logic [15:0] pt;
   } vec_t;

   localparam vec_t VEC [6] = '{
      '{y:16'd100, s:16'd50,  inc:1'b0, acc:1'b1, pt:16'd50},
      '{y:16'd100, s:16'd100, inc:1'b1, acc:1'b1, pt:16'd99},
      '{y:16'd100, s:16'd101, inc:1'b0, acc:1'b0, pt:16'd0},
      '{y:16'd200, s:16'd200, inc:1'b0, acc:1'b1, pt:16'd200},
      '{y:16'd30,  s:16'd31,  inc:1'b1, acc:1'b0, pt:16'd0},
      '{y:16'd500, s:16'd1,   inc:1'b1, acc:1'b1, pt:16'd0}
   };

   initial begin
      #200000;
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      idle();
      ex_sq_seq = '0; ex_sq_npc = '0; ins_seq = '0;
      rob_head_seq = '0; rob_empty = '1; cur_pc = '0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();

      // R9 reset state
      chk("R9 state", thr_state, 0);
      chk("R9 youngest", youngest, 0);
      chk("R9 flags", {bc_squash, trap_pend, sys_mode, sq_conflict}, 0);
      chk("R9 commit_ok", commit_ok, 2'b11);

      // Vector table on thread 0: R1, R2, R3, R7
      for (int i = 0; i < 6; i++) begin
         finish_walk(0);
         insert(0, VEC[i].y, 1'b0);
         chk("R7 insert sets youngest", yng(0), VEC[i].y);
         exsq(0, VEC[i].s, VEC[i].inc, 1'b1, i[0], 32'h1000 + i);
         step();
         chk("R1 accept", bc_squash[0], VEC[i].acc);
         chk("R1 other thread quiet", bc_squash[1], 0);
         if (VEC[i].acc) begin
            chk("R2 flush point", dseq(0), VEC[i].pt);
            chk("R3 youngest=point", yng(0), VEC[i].pt);
            chk("R3 state flushing", st(0), 1);
            chk("R3 misp", bc_misp[0], 1);
            chk("R3 taken", bc_taken[0], i[0]);
            chk("R3 npc", bc_npc[PCW-1:0], 32'h1000 + i);
            step();
            chk("R3 single pulse", bc_squash[0], 0);
         end else begin
            chk("R1 youngest kept", yng(0), VEC[i].y);
         end
      end

      // R6 hold while flushing; R7 insertions dropped
      finish_walk(0);
      insert(0, 16'd80, 1'b0);
      exsq(0, 16'd70, 1'b0, 1'b0, 1'b0, 32'h0);
      step();
      chk("R6 flushing", st(0), 1);
      chk("R6 commit blocked", commit_ok[0], 0);
      insert(0, 16'd90, 1'b0);
      chk("R7 dropped while flushing", yng(0), 16'd70);
      step(); step();
      chk("R6 still flushing", st(0), 1);
      finish_walk(0);
      chk("R6 back to running", st(0), 0);
      chk("R6 commit allowed", commit_ok[0], 1);
      insert(0, 16'd95, 1'b1);
      chk("R7 dead insert ignored", yng(0), 16'd70);
      // insertion in the same cycle as an accepted flush is dropped
      ins_vld[0] = 1'b1; ins_seq[SEQW-1:0] = 16'd99;
      exsq(0, 16'd60, 1'b0, 1'b0, 1'b0, 32'h0);
      step();
      chk("R7 same-cycle insert dropped", yng(0), 16'd60);
      finish_walk(0);

      // R1 trap-waiting filter, R8 flags
      insert(0, 16'd300, 1'b0);
      trap_arm[0] = 1'b1; sys_enter[0] = 1'b1;
      step();
      chk("R8 trap_pend set", trap_pend[0], 1);
      chk("R8 sys set", sys_mode[0], 1);
      chk("R1 trap state", st(0), 2);
      exsq(0, 16'd10, 1'b0, 1'b0, 1'b0, 32'h0);
      step();
      chk("R1 filtered in trap wait", bc_squash[0], 0);
      // R5 whole flush via external, ROB not empty
      rob_empty[0] = 1'b0; rob_head_seq[SEQW-1:0] = 16'd40;
      cur_pc[PCW-1:0] = 32'hABCD0000;
      ext_sq[0] = 1'b1;
      step();
      chk("R5 point head-1", dseq(0), 16'd39);
      chk("R5 youngest zero", yng(0), 0);
      chk("R5 misp/taken low", {bc_misp[0], bc_taken[0]}, 0);
      chk("R5 npc from cur_pc", bc_npc[PCW-1:0], 32'hABCD0000);
      chk("R8 ext keeps trap_pend", trap_pend[0], 1);
      chk("R8 ext clears sys", sys_mode[0], 0);
      finish_walk(0);

      // R8 trap flush clears both; R5 empty ROB point 0
      sys_enter[0] = 1'b1; rob_empty[0] = 1'b1;
      step();
      trap_sq[0] = 1'b1;
      step();
      chk("R8 trap clears trap_pend", trap_pend[0], 0);
      chk("R8 trap clears sys", sys_mode[0], 0);
      chk("R5 empty point zero", dseq(0), 0);
      finish_walk(0);

      // R4 collision: trap wins (trap_pend cleared), conflict flagged
      trap_arm[0] = 1'b1;
      step();
      trap_sq[0] = 1'b1; ext_sq[0] = 1'b1;
      step();
      chk("R4 conflict flag", sq_conflict[0], 1);
      chk("R4 trap wins", trap_pend[0], 0);
      chk("R4 no conflict thread 1", sq_conflict[1], 0);
      finish_walk(0);

      // R10 override on thread 1
      insert(1, 16'd500, 1'b0);
      rob_empty[1] = 1'b0; rob_head_seq[SEQW +: SEQW] = 16'd20;
      cur_pc[PCW +: PCW] = 32'h5555;
      exsq(1, 16'd400, 1'b0, 1'b1, 1'b1, 32'h7777);
      ext_sq[1] = 1'b1;
      step();
      chk("R10 command", bc_squash[1], 1);
      chk("R10 whole-flush point", dseq(1), 16'd19);
      chk("R10 misp cleared", bc_misp[1], 0);
      chk("R10 npc from cur_pc", bc_npc[PCW +: PCW], 32'h5555);
      chk("R10 thread 0 untouched", bc_squash[0], 0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule